// File: doc/BRIEF.md
# Flash Row Erase Controller

This block is a small register-mapped control unit that erases one row of nonvolatile memory at a time. Software writes a 15-bit target address, picks either the main program array or the user-ID/configuration area, and arms the erase by setting an erase-mode bit and a write-enable bit. The erase itself only starts when two key bytes reach the key register in the right order and the very next write to the control register sets the start bit.

Once an erase is accepted, the block sends a one-cycle row-erase request, with the row base address and the region, to the flash array. It then holds the processor stalled for a fixed number of cycles. At the end it clears the start bit, sets a sticky done flag and, if enabled, raises an interrupt. A protection limit input marks the low rows of the program array as locked. A start aimed at such a row is dropped without any request.

Register map (`reg_sel`): 0 = address low byte; 1 = address high bits (bits 6:0, bit 7 reads 0); 2 = control; 3 = key (write only, reads 0). Control bits: 0 start, 1 write enable, 2 erase mode, 3 region (1 = user-ID/config), 4 done flag, 5 interrupt enable, 7:6 read 0.

Top module: `flash_row_erase`

## Requirements
- R1: After synchronous reset all registers read 0, and `cpu_stall`, `irq` and `erase_req` are 0.
- R2: The address low register holds bits 7:0 and the high register holds bits 14:8 in its bits 6:0. Bit 7 of the high register always reads 0.
- R3: Writing 0x55 to the key register, then 0xAA to the key register, then a control value with start, write enable and erase mode all 1 launches an erase. `erase_req` is high for exactly the one cycle after that control write.
- R4: A start is ignored, and start reads 0, if the key writes come in the wrong order, if a key value is wrong, or if any other register write falls between the keys and the start write.
- R5: A start write whose write-enable bit or erase-mode bit is 0 launches no erase.
- R6: `erase_row` equals the address with its low log2(ROW_WORDS) bits cleared, and `erase_region` equals the region bit.
- R7: With region 0 and a row base below `prot_limit`, a start launches no erase and start reads 0. The user-ID region is never protected.
- R8: `cpu_stall` is high for exactly ERASE_CYCLES cycles, starting with the cycle of `erase_req`. Start reads 1 during that time, and register writes during that time are ignored.
- R9: At the end of an erase the done flag reads 1, and `irq` equals the flag AND the interrupt-enable bit. The flag stays set until software writes 0 to it.
- R10: The write-enable bit keeps its value across an erase.
- R11: Each start attempt consumes the unlock. A second start write with no fresh keys launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| prot_limit | input | 15 | Program rows with a base below this address are locked |
| erase_req | output | 1 | One-cycle row erase request to the array |
| erase_row | output | 15 | Row base address of the erase |
| erase_region | output | 1 | Region of the erase (1 = user-ID/config) |
| cpu_stall | output | 1 | Holds the processor while the erase runs |
| irq | output | 1 | Erase-complete interrupt request |

## Verification
A wrong unlock state shows at the ports on the very next cycle. Either `erase_req` rises after a broken sequence, or it stays low after a correct one. A wrong busy counter shows as a stall that is one or more cycles too short or too long. It also shows as a done flag that appears at the wrong time, and the bench counts this cycle by cycle. A wrong protection compare or row alignment shows in the same cycle as the request, through `erase_req` and `erase_row`.

// File: rtl/flash_row_erase.sv
`timescale 1ns/1ps
module flash_row_erase #(
  parameter int ADDR_W       = 15,
  parameter int ROW_WORDS    = 32,
  parameter int ERASE_CYCLES = 20,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] prot_limit,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_row,
  output logic              erase_region,
  output logic              cpu_stall,
  output logic              irq
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);
  localparam int HI_W     = ADDR_W - 8;
  localparam int CNT_W    = $clog2(ERASE_CYCLES + 1);

  typedef enum logic [1:0] {UL_IDLE, UL_ONE, UL_TWO} ul_t;

  ul_t               ul_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wen_q, mode_q, region_q, ie_q, done_q, busy_q, req_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [ADDR_W-1:0] row_base;
  logic              wr_ok, wr_ctrl, go_req, prot_hit, launch;

  assign row_base = {addr_q[ADDR_W-1:ROW_BITS], {ROW_BITS{1'b0}}};
  assign wr_ok    = reg_we && !busy_q;
  assign wr_ctrl  = wr_ok && reg_sel == 2'd2;
  assign go_req   = wr_ctrl && ul_q == UL_TWO && reg_wdata[0] && reg_wdata[1] && reg_wdata[2];
  assign prot_hit = !reg_wdata[3] && (row_base < prot_limit);
  assign launch   = go_req && !prot_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ul_q <= UL_IDLE;
    end else if (wr_ok) begin
      if (reg_sel == 2'd3 && reg_wdata == KEY_A && ul_q == UL_IDLE)
        ul_q <= UL_ONE;
      else if (reg_sel == 2'd3 && reg_wdata == KEY_B && ul_q == UL_ONE)
        ul_q <= UL_TWO;
      else
        ul_q <= UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_ok && reg_sel == 2'd0) begin
      addr_q[7:0] <= reg_wdata;
    end else if (wr_ok && reg_sel == 2'd1) begin
      addr_q[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q    <= 1'b0;
      mode_q   <= 1'b0;
      region_q <= 1'b0;
      ie_q     <= 1'b0;
    end else if (wr_ctrl) begin
      wen_q    <= reg_wdata[1];
      mode_q   <= reg_wdata[2];
      region_q <= reg_wdata[3];
      ie_q     <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (wr_ctrl)
        done_q <= done_q & reg_wdata[4];
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = addr_q[7:0];
      2'd1:    reg_rdata = 8'(addr_q[ADDR_W-1:8]);
      2'd2:    reg_rdata = {2'b00, ie_q, done_q, region_q, mode_q, wen_q, busy_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign erase_req    = req_q;
  assign erase_row    = row_base;
  assign erase_region = region_q;
  assign cpu_stall    = busy_q;
  assign irq          = done_q && ie_q;
endmodule

// File: rtl/flash_row_erase_chk.sv
`timescale 1ns/1ps
module flash_row_erase_chk #(
  parameter int ADDR_W       = 15,
  parameter int ROW_WORDS    = 32,
  parameter int ERASE_CYCLES = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              erase_req,
  input logic [ADDR_W-1:0] erase_row,
  input logic              cpu_stall,
  input logic              done_q,
  input logic              wen_q
);
  localparam int ROW_BITS = $clog2(ROW_WORDS);
  int unsigned stall_n;

  always_ff @(posedge clk) begin
    if (rst)            stall_n <= 0;
    else if (erase_req) stall_n <= 1;
    else if (cpu_stall) stall_n <= stall_n + 1;
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);
  p_req_stalls_r8: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> cpu_stall);
  p_stall_from_req_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |-> erase_req);
  p_stall_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> stall_n == ERASE_CYCLES);
  p_done_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> done_q);
  p_row_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> erase_row[ROW_BITS-1:0] == '0);
  p_wen_kept_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> $stable(wen_q));
endmodule

bind flash_row_erase flash_row_erase_chk #(
  .ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .erase_req(erase_req), .erase_row(erase_row),
  .cpu_stall(cpu_stall), .done_q(done_q), .wen_q(wen_q)
);

// File: tb/flash_row_erase_tb.sv
`timescale 1ns/1ps
module flash_row_erase_tb_top;
  localparam int AW = 15;
  localparam int RW = 32;
  localparam int EC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] prot_limit = '0;
  logic          erase_req, erase_region, cpu_stall, irq;
  logic [AW-1:0] erase_row;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flash_row_erase #(.ADDR_W(AW), .ROW_WORDS(RW), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_limit(prot_limit),
    .erase_req(erase_req), .erase_row(erase_row), .erase_region(erase_region),
    .cpu_stall(cpu_stall), .irq(irq)
  );

  function automatic logic [AW-1:0] exp_row(input logic [AW-1:0] a);
    return a & ~AW'(RW - 1);
  endfunction

  function automatic bit exp_locked(input bit region, input logic [AW-1:0] a,
                                    input logic [AW-1:0] lim);
    return !region && (exp_row(a) < lim);
  endfunction

  function automatic logic [7:0] ctrl_byte(input bit go, input bit wen, input bit mode,
                                           input bit region, input bit ie);
    return {2'b00, ie, 1'b0, region, mode, wen, go};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // corrupt: 0 clean, 1 keys swapped, 2 write between keys, 3 wrong second key
  task automatic attempt(input logic [AW-1:0] a, input bit region, input bit ie,
                         input bit wen, input bit mode, input int corrupt);
    logic [7:0] r;
    bit exp_go;
    int n;
    exp_go = wen && mode && corrupt == 0 && !exp_locked(region, a, prot_limit);
    wr(2'd0, a[7:0]);
    wr(2'd1, 8'(a[AW-1:8]));
    wr(2'd2, ctrl_byte(1'b0, wen, mode, region, ie));
    case (corrupt)
      1: begin wr(2'd3, 8'hAA); wr(2'd3, 8'h55); end
      2: begin wr(2'd3, 8'h55); wr(2'd0, a[7:0]); wr(2'd3, 8'hAA); end
      3: begin wr(2'd3, 8'h55); wr(2'd3, 8'h56); end
      default: begin wr(2'd3, 8'h55); wr(2'd3, 8'hAA); end
    endcase
    wr(2'd2, ctrl_byte(1'b1, wen, mode, region, ie));
    // R3 R4 R5 R7: request appears the cycle after the start write, or never
    check(erase_req == exp_go, "R3/R4/R5/R7 erase_req", erase_req, exp_go);
    if (exp_go) begin
      check(erase_row == exp_row(a), "R6 row base", erase_row, exp_row(a));
      check(erase_region == region, "R6 region", erase_region, region);
      rd(2'd2, r);
      check(r[0] == 1'b1, "R8 start reads 1 while busy", r[0], 1);
      wr(2'd0, 8'h3C);
      n = 1;
      while (cpu_stall && n < 1000) begin n++; @(negedge clk); end
      check(n == EC, "R8 stall length", n, EC);
      rd(2'd0, r);
      check(r == a[7:0], "R8 write during busy ignored", r, a[7:0]);
      rd(2'd2, r);
      check(r[0] == 1'b0 && r[4] == 1'b1, "R9 done set, start cleared", r, 8'h10);
      check(irq == ie, "R9 irq follows enable", irq, ie);
      check(r[1] == wen, "R10 write enable kept", r[1], wen);
      repeat (3) @(negedge clk);
      rd(2'd2, r);
      check(r[4] == 1'b1, "R9 done sticky", r[4], 1);
      wr(2'd2, ctrl_byte(1'b1, wen, mode, region, ie));
      check(erase_req == 1'b0, "R11 no relaunch without keys", erase_req, 0);
      rd(2'd2, r);
      check(r[4] == 1'b0 && irq == 1'b0, "R9 done cleared by write 0", r, 0);
    end else begin
      repeat (2) @(negedge clk);
      rd(2'd2, r);
      check(r[0] == 1'b0 && !cpu_stall, "R4/R5/R7 start not taken", r[0], 0);
    end
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(2'd0, r); check(r == 8'h00, "R1 addr lo reset", r, 0);
    rd(2'd1, r); check(r == 8'h00, "R1 addr hi reset", r, 0);
    rd(2'd2, r); check(r == 8'h00, "R1 ctrl reset", r, 0);
    check(!cpu_stall && !irq && !erase_req, "R1 outputs reset",
          {cpu_stall, irq, erase_req}, 0);
    // R2
    wr(2'd0, 8'hA5); wr(2'd1, 8'hFF);
    rd(2'd0, r); check(r == 8'hA5, "R2 addr lo", r, 8'hA5);
    rd(2'd1, r); check(r == 8'h7F, "R2 addr hi masked", r, 8'h7F);
    rd(2'd3, r); check(r == 8'h00, "R2 key reads 0", r, 0);
    // R4 start with no keys at all
    wr(2'd2, ctrl_byte(1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
    check(erase_req == 1'b0, "R4 start without keys", erase_req, 0);
    prot_limit = 15'h0400;
    attempt(15'h1234, 1'b0, 1'b1, 1'b1, 1'b1, 0);  // R3 R6 R8 R9 R10 R11
    attempt(15'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1);  // R4 swapped
    attempt(15'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 2);  // R4 interleaved write
    attempt(15'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 3);  // R4 wrong key
    attempt(15'h1234, 1'b0, 1'b1, 1'b0, 1'b1, 0);  // R5 no wen
    attempt(15'h1234, 1'b0, 1'b1, 1'b1, 1'b0, 0);  // R5 no mode
    attempt(15'h03FF, 1'b0, 1'b1, 1'b1, 1'b1, 0);  // R7 locked row
    attempt(15'h0400, 1'b0, 1'b0, 1'b1, 1'b1, 0);  // R7 first free row
    attempt(15'h0005, 1'b1, 1'b1, 1'b1, 1'b1, 0);  // R7 user-ID never locked
    for (int i = 0; i < 40; i++) begin
      int c;
      c = ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0;
      prot_limit = AW'($urandom);
      attempt(AW'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 5) != 0, ($urandom % 5) != 0, c);
    end
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done_run) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule